// File: doc/BRIEF.md
# Trigger Latency Buffer with Derandomizer

The block records one wide detector word on every bunch crossing into a circular buffer. Each word stays there for a fixed, configurable trigger latency. When a trigger accept arrives, the block selects a window of one to three consecutive crossings. The first crossing in the window is the one `cfg_latency` clocks older than the accept. The block captures the whole window in a single cycle. It then writes a header entry followed by the window words into a derandomizing FIFO. The FIFO absorbs bursts of accepts, and a downstream formatter drains it through a show-ahead read port.

A bunch-crossing counter and an event counter tag every event. Both counters have their own clear inputs.

- **Pending slot.** An accept is parked in a single pending slot.
- **Controller states.**
  - `XS_IDLE` waits for work. It takes the pending event and moves to `XS_HEAD`.
  - `XS_HEAD` writes the header and then always moves to `XS_WORD`.
  - `XS_WORD` writes one window word per cycle. After the last word it moves to `XS_HEAD` if another event is pending, and to `XS_IDLE` otherwise.
- **Dropped accepts.** An accept is dropped in two cases: the FIFO cannot guarantee room for the whole event, or the pending slot is still occupied. A drop raises a sticky overflow flag and increments a saturating drop counter.

Top module: `trig_latency_buffer`

## Requirements
- R1: Every clock writes `din` into the circular buffer. An accept sampled at edge k with effective latency L and effective crossing count n yields data entries `din(k-L)`, `din(k-L+1)` … `din(k-L+n-1)`, in that order, directly after its header.
- R2: The effective latency is `cfg_latency` clamped to the range 3 … PIPE_DEPTH-1. With the default depth of 164, a setting of 0 acts as 3 and a setting of 200 acts as 163.
- R3: The effective crossing count is `cfg_ncross` with 0 treated as 1. Values 1 to 3 are used as given.
- R4: A header entry has `rd_hdr`=1 and data entries have `rd_hdr`=0. The header `rd_data` layout is:
  - bits [11:0]: the bunch count at the accept edge
  - bits [23:12]: the event number
  - bits [25:24]: the effective crossing count
  - all higher bits: zero
- R5: The bunch count starts at 0 after reset and increments every clock, wrapping modulo 4096. `bx_reset` makes it 0 at the next edge. An accept on that same edge still reports the old value.
- R6: The event number is the count of accepts since reset or the last `evt_reset`, counting dropped accepts too. An accept on the same edge as `evt_reset` reports the old value, and the next accept reports 0.
- R7: An accept is dropped when the FIFO's free entries, minus those already reserved by earlier events, are fewer than n+1. An event is never split.
- R8: One pending slot holds an accepted event until the controller takes it. With n=1, three accepts on consecutive edges store the first two and drop the third.
- R9: A drop sets `ovf_flag`, which stays set until reset. A drop also increments `ovf_count`, which saturates at 255.
- R10: `rd_valid` is high exactly when the FIFO holds an entry. `rd_en` pops the head entry, and entries come out in write order. `rd_en` while the FIFO is empty has no effect.
- R11: `rst_n` low does the following:
  - empties the FIFO
  - clears the pending slot, the counters, `ovf_flag` and `ovf_count`
  - restarts the write position
- R12: Accepts closer together than the window length are all honoured when the slot allows it. Two adjacent n=3 accepts produce two complete events whose windows share two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| bx_reset | input | 1 | Clears the bunch counter |
| evt_reset | input | 1 | Clears the event counter |
| trig_acc | input | 1 | Trigger accept, one cycle per event |
| cfg_latency | input | 8 | Requested latency in crossings |
| cfg_ncross | input | 2 | Requested crossings per event |
| din | input | 240 | Detector word of the current crossing |
| rd_en | input | 1 | Pop the FIFO head |
| rd_valid | output | 1 | FIFO head is valid |
| rd_hdr | output | 1 | FIFO head is a header entry |
| rd_data | output | 240 | FIFO head payload |
| ovf_flag | output | 1 | Sticky drop indicator |
| ovf_count | output | 8 | Saturating drop count |

## Verification
The bench sweeps several latency settings against every crossing-count code, including both clamped latency ends and a count of 0. A wrong read-address offset or a missing clamp would return words from the wrong crossings. It drives adjacent accepts with overlapping windows and a three-accept burst. A design that mishandled the pending-slot hand-off would lose the second event or keep the third. It fills the FIFO with four-entry events, checks that the thirteenth is refused whole, and drives 260 further drops. This would expose a room check that ignores reservations, a counter that wraps instead of saturating, or a split event. Crossing-counter wrap, both counter clears on their edge cases, pops on an empty FIFO, and a reset in the middle of traffic are each followed by a normal event. The bench confirms that no state leaks through.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Controller states of the event extractor
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_HEAD = 2'd1,
        XS_WORD = 2'd2
    } xtr_state_t;
endpackage

// File: rtl/tlb_pipeline.sv
// Latency-addressed circular buffer with one read port per window crossing.
module tlb_pipeline #(
    parameter int DATA_W = 240,
    parameter int DEPTH  = 164,
    parameter int NWIN   = 3,
    parameter int PA_W   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DATA_W-1:0]      din,
    input  logic [PA_W-1:0]        cfg_lat,
    output logic [NWIN*DATA_W-1:0] win_words
);
    // Window words up to k-L+NWIN-1 must already be written at edge k.
    localparam int MIN_LAT = NWIN;
    localparam int MAX_LAT = DEPTH - 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PA_W-1:0]   wr_ptr;
    logic [PA_W-1:0]   lat_eff;

    always_comb begin
        if (cfg_lat < PA_W'(MIN_LAT))
            lat_eff = PA_W'(MIN_LAT);
        else if (cfg_lat > PA_W'(MAX_LAT))
            lat_eff = PA_W'(MAX_LAT);
        else
            lat_eff = cfg_lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_ptr == PA_W'(DEPTH - 1))
            wr_ptr <= '0;
        else
            wr_ptr <= wr_ptr + PA_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst_n)
            mem[wr_ptr] <= din;
    end

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_rd
            logic [PA_W:0]   sum;
            logic [PA_W-1:0] addr;
            always_comb begin
                sum = {1'b0, wr_ptr} + (PA_W+1)'(DEPTH) - {1'b0, lat_eff} + (PA_W+1)'(g);
                if (sum >= (PA_W+1)'(DEPTH))
                    addr = PA_W'(sum - (PA_W+1)'(DEPTH));
                else
                    addr = sum[PA_W-1:0];
            end
            assign win_words[g*DATA_W +: DATA_W] = mem[addr];
        end
    endgenerate
endmodule

// File: rtl/tlb_tagger.sv
// Bunch-crossing and event counters used to tag each event.
module tlb_tagger #(
    parameter int BX_W  = 12,
    parameter int EVT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bx_clr,
    input  logic             evt_clr,
    input  logic             acc,
    output logic [BX_W-1:0]  bx,
    output logic [EVT_W-1:0] evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bx  <= '0;
            evt <= '0;
        end else begin
            bx <= bx_clr ? '0 : bx + BX_W'(1);
            if (evt_clr)
                evt <= '0;
            else if (acc)
                evt <= evt + EVT_W'(1);
        end
    end
endmodule

// File: rtl/tlb_extract.sv
// Event extractor: pending slot, room check, header/word sequencing, drop tally.
module tlb_extract import tlb_pkg::*; #(
    parameter int DATA_W = 240,
    parameter int NWIN   = 3,
    parameter int BX_W   = 12,
    parameter int EVT_W  = 12,
    parameter int OVF_W  = 8,
    parameter int CNT_W  = 6,
    parameter int NC_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc,
    input  logic [NC_W-1:0]        ncross,
    input  logic [BX_W-1:0]        bx,
    input  logic [EVT_W-1:0]       evt,
    input  logic [NWIN*DATA_W-1:0] win_words,
    input  logic [CNT_W-1:0]       free_cnt,
    output logic                   reserve,
    output logic [CNT_W-1:0]       reserve_amt,
    output logic                   wr_en,
    output logic                   wr_hdr,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   drop,
    output logic                   ovf_flag,
    output logic [OVF_W-1:0]       ovf_count
);
    localparam int WIN_W = NWIN * DATA_W;
    localparam int HDR_W = NC_W + EVT_W + BX_W;

    xtr_state_t state, state_nx;

    logic              pend_v;
    logic [BX_W-1:0]   pend_bx,  act_bx;
    logic [EVT_W-1:0]  pend_evt, act_evt;
    logic [NC_W-1:0]   pend_n,   act_n;
    logic [WIN_W-1:0]  pend_words, act_words;
    logic [NC_W-1:0]   idx;

    logic [NC_W-1:0]   nc_eff;
    logic [CNT_W-1:0]  need;
    logic              last_word, take, slot_free, room, keep;
    logic [HDR_W-1:0]  hdr_bits;

    always_comb begin
        if (ncross == '0)
            nc_eff = NC_W'(1);
        else if (ncross > NC_W'(NWIN))
            nc_eff = NC_W'(NWIN);
        else
            nc_eff = ncross;
        need = CNT_W'(nc_eff) + CNT_W'(1);
    end

    assign last_word = (state == XS_WORD) && (idx == act_n - NC_W'(1));
    assign take      = pend_v && ((state == XS_IDLE) || last_word);
    assign slot_free = !pend_v || take;
    assign room      = free_cnt >= need;
    assign keep      = acc && slot_free && room;
    assign drop      = acc && !keep;

    assign reserve     = keep;
    assign reserve_amt = need;
    assign hdr_bits    = {act_n, act_evt, act_bx};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= XS_IDLE;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            XS_IDLE: if (take) state_nx = XS_HEAD;
            XS_HEAD: state_nx = XS_WORD;
            XS_WORD: if (last_word) state_nx = take ? XS_HEAD : XS_IDLE;
            default: state_nx = XS_IDLE;
        endcase
    end

    // Outputs toward the derandomizer
    always_comb begin
        wr_en   = 1'b0;
        wr_hdr  = 1'b0;
        wr_data = '0;
        unique case (state)
            XS_IDLE: ;
            XS_HEAD: begin
                wr_en   = 1'b1;
                wr_hdr  = 1'b1;
                wr_data = DATA_W'(hdr_bits);
            end
            XS_WORD: begin
                wr_en   = 1'b1;
                wr_data = act_words[int'(idx)*DATA_W +: DATA_W];
            end
            default: ;
        endcase
    end

    // Pending slot, active event, word index, drop tally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_bx    <= '0;
            pend_evt   <= '0;
            pend_n     <= '0;
            pend_words <= '0;
            act_bx     <= '0;
            act_evt    <= '0;
            act_n      <= NC_W'(1);
            act_words  <= '0;
            idx        <= '0;
            ovf_flag   <= 1'b0;
            ovf_count  <= '0;
        end else begin
            if (keep) begin
                pend_v     <= 1'b1;
                pend_bx    <= bx;
                pend_evt   <= evt;
                pend_n     <= nc_eff;
                pend_words <= win_words;
            end else if (take) begin
                pend_v <= 1'b0;
            end
            if (take) begin
                act_bx    <= pend_bx;
                act_evt   <= pend_evt;
                act_n     <= pend_n;
                act_words <= pend_words;
            end
            if (state == XS_HEAD)
                idx <= '0;
            else if (state == XS_WORD)
                idx <= idx + NC_W'(1);
            if (drop) begin
                ovf_flag <= 1'b1;
                if (ovf_count != '1)
                    ovf_count <= ovf_count + OVF_W'(1);
            end
        end
    end
endmodule

// File: rtl/tlb_derand.sv
// Derandomizing FIFO with space reservation and show-ahead read port.
module tlb_derand #(
    parameter int DATA_W = 240,
    parameter int DEPTH  = 48,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int DA_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reserve,
    input  logic [CNT_W-1:0]  reserve_amt,
    input  logic              wr_en,
    input  logic              wr_hdr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic              rd_hdr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  free_cnt
);
    logic [DATA_W:0]  mem [DEPTH];
    logic [DA_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0] count, committed, cnt_nx, com_nx;
    logic             pop;

    assign pop = rd_en && (count != '0);

    always_comb begin
        cnt_nx = count;
        if (wr_en) cnt_nx = cnt_nx + CNT_W'(1);
        if (pop)   cnt_nx = cnt_nx - CNT_W'(1);
        com_nx = committed;
        if (reserve) com_nx = com_nx + reserve_amt;
        if (pop)     com_nx = com_nx - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            committed <= '0;
        end else begin
            if (wr_en)
                wptr <= (wptr == DA_W'(DEPTH - 1)) ? '0 : wptr + DA_W'(1);
            if (pop)
                rptr <= (rptr == DA_W'(DEPTH - 1)) ? '0 : rptr + DA_W'(1);
            count     <= cnt_nx;
            committed <= com_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wptr] <= {wr_hdr, wr_data};
    end

    assign rd_valid          = (count != '0);
    assign {rd_hdr, rd_data} = mem[rptr];
    assign free_cnt          = CNT_W'(DEPTH) - committed;
endmodule

// File: rtl/trig_latency_buffer.sv
// Top: latency buffer, tagger, extractor and derandomizer.
module trig_latency_buffer #(
    parameter int DATA_W       = 240,
    parameter int PIPE_DEPTH   = 164,
    parameter int DERAND_DEPTH = 48,
    parameter int NWIN         = 3,
    parameter int BX_W         = 12,
    parameter int EVT_W        = 12,
    parameter int OVF_W        = 8,
    localparam int PA_W  = $clog2(PIPE_DEPTH),
    localparam int DA_W  = $clog2(DERAND_DEPTH),
    localparam int CNT_W = $clog2(DERAND_DEPTH + 1),
    localparam int NC_W  = $clog2(NWIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bx_reset,
    input  logic              evt_reset,
    input  logic              trig_acc,
    input  logic [PA_W-1:0]   cfg_latency,
    input  logic [NC_W-1:0]   cfg_ncross,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic              rd_hdr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic [OVF_W-1:0]  ovf_count
);
    logic [NWIN*DATA_W-1:0] win_words;
    logic [BX_W-1:0]        bx_now;
    logic [EVT_W-1:0]       evt_now;
    logic [CNT_W-1:0]       free_cnt, reserve_amt;
    logic                   reserve, fifo_wr_en, fifo_wr_hdr, drop;
    logic [DATA_W-1:0]      fifo_wr_data;

    tlb_pipeline #(
        .DATA_W(DATA_W), .DEPTH(PIPE_DEPTH), .NWIN(NWIN), .PA_W(PA_W)
    ) u_pipe (
        .clk(clk), .rst_n(rst_n), .din(din), .cfg_lat(cfg_latency), .win_words(win_words)
    );

    tlb_tagger #(
        .BX_W(BX_W), .EVT_W(EVT_W)
    ) u_tag (
        .clk(clk), .rst_n(rst_n), .bx_clr(bx_reset), .evt_clr(evt_reset),
        .acc(trig_acc), .bx(bx_now), .evt(evt_now)
    );

    tlb_extract #(
        .DATA_W(DATA_W), .NWIN(NWIN), .BX_W(BX_W), .EVT_W(EVT_W),
        .OVF_W(OVF_W), .CNT_W(CNT_W), .NC_W(NC_W)
    ) u_xtr (
        .clk(clk), .rst_n(rst_n), .acc(trig_acc), .ncross(cfg_ncross),
        .bx(bx_now), .evt(evt_now), .win_words(win_words), .free_cnt(free_cnt),
        .reserve(reserve), .reserve_amt(reserve_amt),
        .wr_en(fifo_wr_en), .wr_hdr(fifo_wr_hdr), .wr_data(fifo_wr_data),
        .drop(drop), .ovf_flag(ovf_flag), .ovf_count(ovf_count)
    );

    tlb_derand #(
        .DATA_W(DATA_W), .DEPTH(DERAND_DEPTH), .CNT_W(CNT_W), .DA_W(DA_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .reserve(reserve), .reserve_amt(reserve_amt),
        .wr_en(fifo_wr_en), .wr_hdr(fifo_wr_hdr), .wr_data(fifo_wr_data),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_hdr(rd_hdr), .rd_data(rd_data),
        .free_cnt(free_cnt)
    );
endmodule

// File: rtl/tlb_checker.sv
// Temporal properties of the trigger latency buffer, bound into the top.
module tlb_checker #(
    parameter int BX_W         = 12,
    parameter int OVF_W        = 8,
    parameter int CNT_W        = 6,
    parameter int DERAND_DEPTH = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bx_reset,
    input logic [BX_W-1:0]  bx,
    input logic             wr_en,
    input logic             wr_hdr,
    input logic             drop,
    input logic             ovf_flag,
    input logic [OVF_W-1:0] ovf_count,
    input logic [CNT_W-1:0] free_cnt
);
    // R5: counter advances by one when not cleared
    a_r5_bx_step: assert property (@(posedge clk) disable iff (!rst_n)
        !bx_reset |=> bx == BX_W'($past(bx) + BX_W'(1)));

    // R5: clear lands on the next edge
    a_r5_bx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bx_reset |=> bx == '0);

    // R4: a header is always followed by a data entry
    a_r4_hdr_then_word: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hdr |=> wr_en && !wr_hdr);

    // R9: flag is sticky
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R9: a drop raises the flag and advances or holds a saturated count
    a_r9_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_flag && ((ovf_count == OVF_W'($past(ovf_count) + OVF_W'(1))) || (&ovf_count)));

    // R7: reservations never exceed the FIFO depth
    a_r7_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(DERAND_DEPTH));
endmodule

bind trig_latency_buffer tlb_checker #(
    .BX_W(BX_W), .OVF_W(OVF_W), .CNT_W(CNT_W), .DERAND_DEPTH(DERAND_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bx_reset(bx_reset), .bx(bx_now),
    .wr_en(fifo_wr_en), .wr_hdr(fifo_wr_hdr), .drop(drop),
    .ovf_flag(ovf_flag), .ovf_count(ovf_count), .free_cnt(free_cnt)
);

// File: tb/tb_trig_latency_buffer.sv
module tb_trig_latency_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 240;
    localparam int PD = 164;
    localparam int DD = 48;
    localparam int NW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bx_reset = 1'b0;
    logic          evt_reset = 1'b0;
    logic          trig_acc = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    cfg_latency = 8'd0;
    logic [1:0]    cfg_ncross = 2'd1;
    logic [DW-1:0] din = '0;
    logic          rd_valid, rd_hdr, ovf_flag;
    logic [DW-1:0] rd_data;
    logic [7:0]    ovf_count;

    int checks = 0;
    int failures = 0;
    int k = 0;
    int bx_m = 0;
    int evt_m = 0;
    int comm_m = 0;
    int ovf_m = 0;
    logic [DW:0] expq[$];
    int lat_set[6] = '{0, 3, 4, 9, 163, 200};

    trig_latency_buffer dut (
        .clk(clk), .rst_n(rst_n), .bx_reset(bx_reset), .evt_reset(evt_reset),
        .trig_acc(trig_acc), .cfg_latency(cfg_latency), .cfg_ncross(cfg_ncross),
        .din(din), .rd_en(rd_en), .rd_valid(rd_valid), .rd_hdr(rd_hdr),
        .rd_data(rd_data), .ovf_flag(ovf_flag), .ovf_count(ovf_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(int kk);
        logic [255:0] t;
        t = {8{kk}};
        return t[DW-1:0];
    endfunction

    task automatic chk(string req, logic [DW:0] act, logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One clock; the model tracks the edge just taken, then inputs for the next edge.
    task automatic step();
        @(posedge clk);
        if (rst_n) begin
            bx_m  = bx_reset ? 0 : (bx_m + 1) % 4096;
            evt_m = evt_reset ? 0 : (trig_acc ? (evt_m + 1) % 4096 : evt_m);
            k++;
        end
        #1;
        din = pat(k);
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic accept(int n_raw, int lat_raw, bit busy);
        int n;
        int L;
        n = (n_raw == 0) ? 1 : ((n_raw > NW) ? NW : n_raw);
        L = (lat_raw < NW) ? NW : ((lat_raw > PD - 1) ? PD - 1 : lat_raw);
        cfg_ncross  = 2'(n_raw);
        cfg_latency = 8'(lat_raw);
        if (busy || (DD - comm_m < n + 1)) begin
            if (ovf_m < 255) ovf_m++;
        end else begin
            comm_m += n + 1;
            expq.push_back({1'b1, DW'((n << 24) | (evt_m << 12) | bx_m)});
            for (int j = 0; j < n; j++) expq.push_back({1'b0, pat(k - L + j)});
        end
        trig_acc = 1'b1;
        step();
        trig_acc = 1'b0;
    endtask

    // Pops every entry; headers are checked under R4, data under the given tag.
    task automatic drain(string req);
        while (rd_valid) begin
            logic [DW:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : '1;
            chk(e[DW] ? "R4" : req, {rd_hdr, rd_data}, e);
            rd_en = 1'b1;
            step();
            rd_en = 1'b0;
            comm_m--;
        end
        chk(req, (DW+1)'(expq.size()), '0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        din = pat(0);
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", rd_valid, 0);
        chk("R11", ovf_flag, 0);
        chk("R11", ovf_count, 0);
        rst_n = 1'b1;
        idle(170);

        // R1 R2 R3 sweep over latency settings and crossing codes
        for (int li = 0; li < 6; li++) begin
            for (int n = 0; n < 4; n++) begin
                accept(n, lat_set[li], 1'b0);
                idle(6);
                if (lat_set[li] == 0 || lat_set[li] == 200) drain("R2");
                else if (n == 0) drain("R3");
                else drain("R1");
            end
        end
        chk("R9", ovf_flag, 0);

        // R12: adjacent three-crossing events with overlapping windows
        accept(3, 5, 1'b0);
        accept(3, 5, 1'b0);
        idle(10);
        drain("R12");

        // R8: three adjacent single-crossing accepts, third hits a busy slot
        accept(1, 5, 1'b0);
        accept(1, 5, 1'b0);
        accept(1, 5, 1'b1);
        idle(8);
        chk("R8", ovf_count, 8'(ovf_m));
        chk("R8", ovf_flag, 1);
        drain("R8");

        // R5: clear then wrap
        bx_reset = 1'b1;
        accept(2, 5, 1'b0);
        bx_reset = 1'b0;
        idle(4);
        accept(2, 5, 1'b0);
        idle(6);
        drain("R5");
        idle(4100);
        accept(1, 5, 1'b0);
        idle(6);
        drain("R5");

        // R6: event clear on the same edge as an accept
        evt_reset = 1'b1;
        accept(1, 5, 1'b0);
        evt_reset = 1'b0;
        idle(6);
        accept(1, 5, 1'b0);
        idle(6);
        drain("R6");

        // R10: pops on an empty FIFO are harmless
        rd_en = 1'b1;
        idle(3);
        rd_en = 1'b0;
        chk("R10", rd_valid, 0);
        accept(2, 7, 1'b0);
        idle(6);
        chk("R10", rd_valid, 1);
        drain("R10");

        // R7: fill with four-entry events, thirteenth refused whole
        for (int i = 0; i < 13; i++) begin
            accept(3, 9, 1'b0);
            idle(5);
        end
        accept(1, 9, 1'b0);
        chk("R7", ovf_count, 8'(ovf_m));
        // R9: saturation
        repeat (260) accept(1, 9, 1'b0);
        idle(2);
        chk("R9", ovf_count, 8'd255);
        chk("R9", ovf_flag, 1);
        drain("R7");
        chk("R9", ovf_count, 8'd255);

        // R11: reset in the middle of traffic
        accept(2, 9, 1'b0);
        idle(6);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R11", rd_valid, 0);
        chk("R11", ovf_flag, 0);
        chk("R11", ovf_count, 0);
        k = 0; bx_m = 0; evt_m = 0; comm_m = 0; ovf_m = 0;
        expq.delete();
        din = pat(0);
        rst_n = 1'b1;
        idle(170);
        accept(2, 9, 1'b0);
        idle(6);
        drain("R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule